// File: doc/BRIEF.md
# Flash command interface controller

This block wraps a small word-wide storage array with the bus behaviour of a single-supply NOR flash. The host drives chip select, write enable, output enable, an address and a data byte. It does not write the array directly. It writes unlock and command cycles. A decoder recognises these cycles and starts an internally timed program or sector-erase operation. While an operation runs, a read returns a status byte instead of array data, and the ready/busy pin is held low. When the operation ends, the pin goes high again and reads return the array.

A two-cycle program mode can be entered so that repeated programming skips the unlock writes. An erase can be suspended so that other sectors can be read or programmed, and then resumed. Each sector has a lock input. A write-inhibit input masks every bus write. A synchronous active-low reset aborts any operation and returns the decoder to read mode. Reset does not touch array contents, and the array starts out fully erased.

Bus cycles are sampled on the rising clock edge. A write cycle is `cs_n`=0 and `we_n`=0. A read cycle is `cs_n`=0, `oe_n`=0 and `we_n`=1.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `ry_by_n` is 1, `dout` is 0, and a read of any word returns 0xFF (erased).
- R2: A program is started by four writes: 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then target address/data. From the cycle after the last write, `ry_by_n` is 0 for exactly PROG_CYC cycles. After that the word holds old AND new, so bits can only go from 1 to 0.
- R3: A write whose address or data does not match the expected unlock or command value discards the partial sequence. That write is not taken as the start of a new sequence.
- R4: A read while busy returns a status byte one cycle after the read cycle. Bit 7 is the complement of bit 7 of the data being programmed, and is 0 during an erase. Bit 6 alternates on every status read, and starts at 0 after reset. Bits 5..0 are 0.
- R5: After an operation completes, reads return array data and a new command is accepted.
- R6: A sector erase takes six writes: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, then any address in the sector with data 0x30. Address bits [5:4] select one of four 16-word sectors. On the last write every word of the sector becomes 0x00 (pre-program). After ERASE_CYC busy cycles every word becomes 0xFF. Other sectors are unchanged.
- R7: The write sequence 0x555/0xAA, 0x2AA/0x55, 0x555/0x20 enters two-cycle mode. In that mode a write of 0xA0 at any address, followed by an address/data write, programs. A write of 0x90 followed by 0x00 leaves the mode, and after that 0xA0 alone no longer programs.
- R8: When `sec_lock[s]` is 1, program and erase commands aimed at sector s do not make the block busy and do not change the array.
- R9: While `wr_inhibit` is 1, write cycles have no effect, and any partially entered sequence is kept.
- R10: A write of 0xB0 during an erase suspends it. `ry_by_n` goes to 1 on the next cycle and the erase timer stops. While suspended, other sectors can be read and programmed, and a program aimed at the erasing sector is ignored. A write of 0x30 in read state resumes the erase for its remaining cycles.
- R11: Reset aborts a running program or erase, leaves two-cycle mode, and keeps whatever the array already holds.
- R12: While a program runs, all writes are ignored. While an erase runs unsuspended, only 0xB0 has an effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous hardware reset, active low |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wr_inhibit | input | 1 | Blocks all write cycles when 1 |
| sec_lock | input | 2**SW | Per-sector lock mask |
| addr | input | AW | Word / command address |
| din | input | DW | Write data / command byte |
| dout | output | DW | Read data or status, registered |
| ry_by_n | output | 1 | 1 = ready, 0 = busy |

## Verification
A read presented in one cycle shows on `dout` after the next rising edge. The bench drives at the falling edge and samples just after the rising edge that follows. `ry_by_n` falls one edge after the final command write. It stays low for PROG_CYC cycles for a program, or for ERASE_CYC running cycles for an erase. A suspend or reset takes effect at the next edge. The behavioural model in the bench advances once per driven cycle and predicts `ry_by_n` and `dout` at each falling edge, so every one of these latencies is checked on every clock rather than only at the end of an operation.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int MW = 6,
  parameter int SW = 2,
  parameter int PROG_CYC = 6,
  parameter int ERASE_CYC = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic               wr_inhibit,
  input  logic [(1<<SW)-1:0] sec_lock,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      din,
  output logic [DW-1:0]      dout,
  output logic               ry_by_n
);
  localparam int SWORDS = 1 << (MW - SW);
  localparam int PCW = $clog2(PROG_CYC) + 1;
  localparam int ECW = $clog2(ERASE_CYC) + 1;
  localparam logic [AW-1:0] KA1 = AW'(12'h555);
  localparam logic [AW-1:0] KA2 = AW'(12'h2AA);

  typedef enum logic [2:0] {C_RD, C_U1, C_U2, C_PG, C_E1, C_E2, C_E3, C_BX} cmd_t;

  cmd_t            st;
  logic            byp, pact, eact, susp, tog;
  logic [PCW-1:0]  pcnt;
  logic [ECW-1:0]  ecnt;
  logic [MW-1:0]   paddr;
  logic [DW-1:0]   pdata;
  logic [SW-1:0]   esec;
  logic [DW-1:0]   mem [0:(1<<MW)-1] = '{default: '1};

  logic            wr, rd, busy, a1, a2, p_done, e_run, e_done, p_ok, p_start, e_start;
  logic [7:0]      cmd, stat;
  logic [SW-1:0]   wsec;
  logic [MW-1:0]   widx;

  assign cmd     = din[7:0];
  assign wsec    = addr[MW-1 -: SW];
  assign widx    = addr[MW-1:0];
  assign wr      = ~cs_n & ~we_n & ~wr_inhibit;
  assign rd      = ~cs_n & ~oe_n & we_n;
  assign a1      = addr == KA1;
  assign a2      = addr == KA2;
  assign busy    = pact | (eact & ~susp);
  assign ry_by_n = ~busy;
  assign p_done  = pact && pcnt == '0;
  assign e_run   = eact & ~susp & ~pact;
  assign e_done  = e_run && ecnt == '0;
  assign p_ok    = ~sec_lock[wsec] && !(eact && wsec == esec);
  assign p_start = wr && !busy && st == C_PG && p_ok;
  assign e_start = wr && !busy && st == C_E3 && cmd == 8'h30 && !sec_lock[wsec];
  assign stat    = {pact ? ~pdata[7] : 1'b0, tog, 6'b0};

  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (p_done) mem[paddr] <= mem[paddr] & pdata;
      for (int i = 0; i < SWORDS; i++) begin
        if (e_start) mem[{wsec, i[MW-SW-1:0]}] <= '0;
        if (e_done)  mem[{esec, i[MW-SW-1:0]}] <= '1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= C_RD; byp <= 1'b0; pact <= 1'b0; eact <= 1'b0; susp <= 1'b0; tog <= 1'b0;
      dout <= '0; pcnt <= '0; ecnt <= '0; paddr <= '0; pdata <= '0; esec <= '0;
    end else begin
      if (p_done) pact <= 1'b0;
      else if (pact) pcnt <= pcnt - 1'b1;
      if (e_done) eact <= 1'b0;
      else if (e_run) ecnt <= ecnt - 1'b1;
      if (rd) begin
        if (busy) begin dout <= DW'(stat); tog <= ~tog; end
        else dout <= mem[widx];
      end
      if (p_start) begin pact <= 1'b1; pcnt <= PCW'(PROG_CYC - 1); paddr <= widx; pdata <= din; end
      if (e_start) begin eact <= 1'b1; ecnt <= ECW'(ERASE_CYC - 1); esec <= wsec; end
      if (wr && busy && !pact) begin
        st <= C_RD;
        if (cmd == 8'hB0 && !e_done) susp <= 1'b1;
      end else if (wr && !busy) begin
        st <= C_RD;
        case (st)
          C_RD: begin
            if (susp && cmd == 8'h30) susp <= 1'b0;
            else if (byp) begin
              if (cmd == 8'hA0) st <= C_PG;
              else if (cmd == 8'h90) st <= C_BX;
            end else if (a1 && cmd == 8'hAA) st <= C_U1;
          end
          C_U1: if (a2 && cmd == 8'h55) st <= C_U2;
          C_U2: if (a1) begin
            if (cmd == 8'hA0) st <= C_PG;
            else if (cmd == 8'h80 && !eact) st <= C_E1;
            else if (cmd == 8'h20) byp <= 1'b1;
          end
          C_E1: if (a1 && cmd == 8'hAA) st <= C_E2;
          C_E2: if (a2 && cmd == 8'h55) st <= C_E3;
          C_BX: if (cmd == 8'h00) byp <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  logic [(1<<SW)-1:0] lock_q;
  always_ff @(posedge clk) lock_q <= sec_lock;

  a_r11_reset_ready: assert property (@(posedge clk) !rst_n |=> ry_by_n);
  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    rd && pact && $past(rd) && $past(pact) |=> dout[6] != $past(dout[6]));
  a_r9_inhibit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inhibit |=> $stable(st) && $stable(byp) && $stable(susp));
  a_r8_lock_prog: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pact) |-> !lock_q[paddr[MW-1 -: SW]]);
  a_r8_lock_erase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eact) |-> !lock_q[esec]);
  a_r10_susp_needs_erase: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> eact);
  a_r12_prog_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    pact && !p_done |=> pact && $stable(paddr) && $stable(pdata));
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  localparam int PROG_CYC = 6;
  localparam int ERASE_CYC = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, inh = 1'b0;
  logic [3:0] lock = 4'b0;
  logic [11:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic ry;

  flash_cmd_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .wr_inhibit(inh),
    .sec_lock(lock), .addr(addr), .din(din), .dout(dout), .ry_by_n(ry));

  int checks = 0, failures = 0;
  string req = "R1";
  bit armed = 0, done = 0, ih_v = 0;
  logic [3:0] nlock = 4'b0;

  int mm [64];
  int p_left = 0, p_a = 0, p_d = 0, e_left = 0, e_sec = 0, m_dout = 0;
  bit msusp = 0, mbyp = 0, mtog = 0;
  int qa[$], qd[$];
  int sa [5][6] = '{'{'h555, 'h2AA, 'h555, -1, 0, 0}, '{'h555, 'h2AA, 'h555, 'h555, 'h2AA, -1},
                    '{'h555, 'h2AA, 'h555, 0, 0, 0}, '{-1, -1, 0, 0, 0, 0}, '{-1, -1, 0, 0, 0, 0}};
  int sd [5][6] = '{'{'hAA, 'h55, 'hA0, -1, 0, 0}, '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h30},
                    '{'hAA, 'h55, 'h20, 0, 0, 0}, '{'hA0, -1, 0, 0, 0, 0}, '{'h90, -1, 0, 0, 0, 0}};
  int slen [5] = '{4, 6, 3, 2, 2};

  initial for (int i = 0; i < 64; i++) mm[i] = 255;

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h at %0t", r, got, exp, $time);
    end
  endtask

  function automatic bit allowed(int k, bit eon);
    if (mbyp) return k == 3 || k == 4;
    return k == 0 || k == 2 || (k == 1 && !eon);
  endfunction

  task automatic model(bit r, bit c, bit w, bit o, bit ih, int a, int d);
    bit pb0, eb0, eon0, edone, wrv, rdv, anyp;
    int ix, sc, hit;
    ix = a & 63; sc = (a >> 4) & 3;
    if (!r) begin
      p_left = 0; e_left = 0; msusp = 0; mbyp = 0; mtog = 0; m_dout = 0;
      qa.delete(); qd.delete(); armed = 1; return;
    end
    pb0 = p_left > 0; eon0 = e_left > 0; eb0 = eon0 && !msusp; edone = 0;
    wrv = !c && !w && !ih; rdv = !c && !o && w;
    if (rdv) begin
      if (pb0 || eb0) begin
        m_dout = ((pb0 ? (((p_d >> 7) & 1) ^ 1) : 0) << 7) | (int'(mtog) << 6);
        mtog = !mtog;
      end else m_dout = mm[ix];
    end
    if (pb0) begin p_left--; if (p_left == 0) mm[p_a] = mm[p_a] & p_d; end
    if (eb0 && !pb0) begin
      e_left--;
      if (e_left == 0) begin for (int j = 0; j < 16; j++) mm[e_sec*16+j] = 255; edone = 1; end
    end
    if (wrv && !pb0) begin
      if (eb0) begin
        qa.delete(); qd.delete();
        if (d == 'hB0 && !edone) msusp = 1;
      end else if (qa.size() == 0 && msusp && d == 'h30) msusp = 0;
      else begin
        qa.push_back(a); qd.push_back(d); hit = -1; anyp = 0;
        for (int k = 0; k < 5; k++) begin
          bit ok;
          ok = allowed(k, eon0) && qa.size() <= slen[k];
          for (int i = 0; i < qa.size() && ok; i++)
            if (!((sa[k][i] < 0 || sa[k][i] == qa[i]) && (sd[k][i] < 0 || sd[k][i] == qd[i]))) ok = 0;
          if (ok) begin anyp = 1; if (qa.size() == slen[k]) hit = k; end
        end
        if (hit == 0 || hit == 3) begin
          if (!nlock[sc] && !(eon0 && sc == e_sec)) begin p_left = PROG_CYC; p_a = ix; p_d = d; end
        end else if (hit == 1) begin
          if (!nlock[sc]) begin
            e_left = ERASE_CYC; e_sec = sc;
            for (int j = 0; j < 16; j++) mm[sc*16+j] = 0;
          end
        end else if (hit == 2) mbyp = 1;
        else if (hit == 4 && d == 0) mbyp = 0;
        if (hit >= 0 || !anyp) begin qa.delete(); qd.delete(); end
      end
    end
  endtask

  task automatic tick(bit r, bit c, bit w, bit o, int a, int d);
    @(negedge clk);
    if (armed) begin
      chk(req, ry, (p_left > 0 || (e_left > 0 && !msusp)) ? 0 : 1);
      chk(req, dout, m_dout);
    end
    rst_n = r; cs_n = c; we_n = w; oe_n = o; inh = ih_v; lock = nlock;
    addr = a[11:0]; din = d[7:0];
    model(r, c, w, o, ih_v, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1, 1, 1, 1, 0, 0);
  endtask
  task automatic wr(int a, int d); tick(1, 0, 0, 1, a, d); endtask
  task automatic rd(int a); tick(1, 0, 1, 0, a, 0); endtask
  task automatic read_val(int a, output logic [7:0] v);
    rd(a); @(posedge clk); #1 v = dout;
  endtask
  task automatic unl(); wr('h555, 'hAA); wr('h2AA, 'h55); endtask
  task automatic prog(int a, int d); unl(); wr('h555, 'hA0); wr(a, d); endtask
  task automatic erase(int a); unl(); wr('h555, 'h80); unl(); wr(a, 'h30); endtask

  initial begin
    logic [7:0] v;
    repeat (3) tick(0, 1, 1, 1, 0, 0);
    req = "R1"; idle(1);
    chk("R1", dout, 8'h00); chk("R1", ry, 1);
    read_val(5, v); chk("R1", v, 8'hFF);

    req = "R2"; prog(5, 'h3C);
    req = "R4"; read_val(5, v); chk("R4", v, 8'h80);
    read_val(5, v); chk("R4", v, 8'hC0);
    idle(6);
    req = "R5"; read_val(5, v); chk("R5", v, 8'h3C);
    req = "R2"; prog(5, 'hF0); idle(8); read_val(5, v); chk("R2", v, 8'h30);

    req = "R3"; wr('h555, 'hAA); wr('h2AA, 'h54); wr(6, 0); idle(8);
    read_val(6, v); chk("R3", v, 8'hFF);
    wr('h554, 'hAA); wr('h2AA, 'h55); wr('h555, 'hA0); wr(6, 0); idle(8);
    read_val(6, v); chk("R3", v, 8'hFF);
    prog(6, 'h11); idle(8); read_val(6, v); chk("R3", v, 8'h11);

    req = "R6"; prog('h12, 0); idle(8); prog('h22, 'h5A); idle(8);
    erase('h10);
    read_val('h13, v); chk("R6", v, 8'h00);
    idle(ERASE_CYC + 4);
    read_val('h12, v); chk("R6", v, 8'hFF);
    read_val('h22, v); chk("R6", v, 8'h5A);
    read_val(5, v); chk("R6", v, 8'h30);

    req = "R8"; nlock = 4'b0100;
    prog('h23, 0); idle(2); chk("R8", ry, 1);
    read_val('h23, v); chk("R8", v, 8'hFF);
    erase('h20); idle(2); chk("R8", ry, 1);
    read_val('h22, v); chk("R8", v, 8'h5A);
    nlock = 4'b0;

    req = "R9"; ih_v = 1; prog('h24, 0); ih_v = 0; idle(8);
    read_val('h24, v); chk("R9", v, 8'hFF);
    unl(); ih_v = 1; wr('h777, 'h12); ih_v = 0; wr('h555, 'hA0); wr('h24, 'h0F); idle(8);
    read_val('h24, v); chk("R9", v, 8'h0F);

    req = "R7"; unl(); wr('h555, 'h20);
    wr(0, 'hA0); wr('h31, 'h81); idle(8);
    read_val('h31, v); chk("R7", v, 8'h81);
    wr(0, 'h90); wr(0, 'h00); wr(0, 'hA0); wr('h32, 0); idle(8);
    read_val('h32, v); chk("R7", v, 8'hFF);

    req = "R12"; prog('h33, 'h77); erase('h30); wr(0, 'hB0); idle(10);
    read_val('h33, v); chk("R12", v, 8'h77);
    read_val('h31, v); chk("R12", v, 8'h81);

    req = "R10"; erase(0); idle(5); wr(0, 'hB0); idle(1); chk("R10", ry, 1);
    read_val('h31, v); chk("R10", v, 8'h81);
    read_val(5, v); chk("R10", v, 8'h00);
    prog('h34, 'h42); idle(8); read_val('h34, v); chk("R10", v, 8'h42);
    prog(7, 0); idle(2); chk("R10", ry, 1);
    wr(0, 'h30); idle(1); chk("R10", ry, 0);
    idle(ERASE_CYC + 2);
    read_val(5, v); chk("R10", v, 8'hFF);
    read_val('h34, v); chk("R10", v, 8'h42);

    req = "R11"; erase('h30); idle(4); tick(0, 1, 1, 1, 0, 0); idle(1); chk("R11", ry, 1);
    read_val('h31, v); chk("R11", v, 8'h00);
    unl(); wr('h555, 'h20); tick(0, 1, 1, 1, 0, 0);
    wr(0, 'hA0); wr('h2A, 0); idle(8);
    read_val('h2A, v); chk("R11", v, 8'hFF);
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL %s watchdog expired got=running expected=finished", req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule